// File: doc/BRIEF.md
# Watermark PAUSE Frame Generator

This block watches how full a receive packet store is and asks the link partner to throttle traffic when space runs short. It compares an occupancy count (in bytes) against two thresholds with hysteresis. When the count climbs to the upper threshold, the block builds an Ethernet MAC Control PAUSE frame that carries a quanta value of 0xFFFF. This asks the far end to stop sending. When the count drains to the lower threshold, the block builds a second PAUSE frame with quanta 0x0000, which lifts the halt.

The frame leaves as a stream of 16-bit words under a valid/ready handshake. Start and end markers sit on the first and last words. The frame is padded with zero words up to the 60-byte minimum that comes before the frame check sequence. The stream feeds a MAC transmit path, which appends the CRC.

The default store size is 64 KiB. With that size the upper threshold is half the store, which is 32768 bytes and is reached after about four 9014-byte jumbo frames. The lower threshold is 30 %, which is 19660 bytes.

Top module: `pause_frame_gen`

## Requirements
- R1: While reset is high, and in the cycle after it, `tx_valid` is 0. A reset in the middle of a frame drops that frame. After reset the block is in the not-halted state with no request queued.
- R2: While not halted, an occupancy of at least the upper threshold (32768 by default) starts a frame. `tx_valid` and `tx_sof` rise on the third rising clock edge after the new occupancy is presented, and not before.
- R3: Once a halt request has been issued, no further request is issued while the occupancy stays above the lower threshold, whatever its value.
- R4: While halted, an occupancy at or below the lower threshold (19660 by default) issues one frame whose quanta word is 0x0000.
- R5: An occupancy strictly between the thresholds issues nothing in either state. So does an occupancy below the upper threshold while not halted.
- R6: The frame words 0 to 8 are, in order: 0x0180, 0xC200, 0x0001, the MAC address bits 47:32, the MAC address bits 31:16, the MAC address bits 15:0, 0x8808, 0x0001, and the quanta word. The quanta word is 0xFFFF for a halt and 0x0000 for a resume.
- R7: A frame is exactly 30 words long, and words 9 to 29 are 0x0000. `tx_sof` is set only on word 0 and `tx_eof` only on word 29.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, the block holds the current word and its markers unchanged, and no word is lost.
- R9: A request that arrives while a frame is in flight is queued. Only the most recent queued request is sent, in the frame that follows, and no further frame is sent after it.
- R10: The source address words come from `local_mac` as it stood when the frame started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| occupancy | input | 17 | Bytes currently held in the receive store |
| local_mac | input | 48 | Station MAC address placed in the source field |
| tx_ready | input | 1 | Downstream accepts the current word |
| tx_valid | output | 1 | A frame word is presented |
| tx_data | output | 16 | Frame word |
| tx_sof | output | 1 | First word of a frame |
| tx_eof | output | 1 | Last word of a frame |

## Verification
Three registers lie between a new occupancy value and the first frame word: the threshold stage, the request queue and the frame builder. The first word is therefore due on the third rising edge after the occupancy is applied. The bench samples a quarter period after each edge and checks that `tx_valid` is still low after two edges and high, with the start marker, after three. Each later word appears one edge after the previous word was accepted. A queued follow-up frame starts two edges after the last word of the previous frame. The bench waits for that frame with a short bounded poll, and it checks held data on the cycle right after every stalled sample.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;

    localparam int WORD_W    = 16;
    localparam int HDR_WORDS = 9;

    localparam logic [WORD_W-1:0] QUANTA_HALT   = 16'hFFFF;
    localparam logic [WORD_W-1:0] QUANTA_RESUME = 16'h0000;

    typedef enum logic [1:0] {
        FB_IDLE,
        FB_HEADER,
        FB_PAD
    } fb_state_e;

    // One flow-control request: halt=1 asks the partner to stop, halt=0 resumes
    typedef struct packed {
        logic valid;
        logic halt;
    } pause_req_t;

    function automatic logic [WORD_W-1:0] quanta_of(input logic halt);
        return halt ? QUANTA_HALT : QUANTA_RESUME;
    endfunction

    // Word at position idx of a MAC Control PAUSE frame (no FCS)
    function automatic logic [WORD_W-1:0] frame_word(
        input int unsigned       idx,
        input logic [47:0]       mac,
        input logic [WORD_W-1:0] quanta
    );
        logic [WORD_W-1:0] w;
        case (idx)
            0:       w = 16'h0180;       // reserved multicast destination
            1:       w = 16'hC200;
            2:       w = 16'h0001;
            3:       w = mac[47:32];     // source, high part first
            4:       w = mac[31:16];
            5:       w = mac[15:0];
            6:       w = 16'h8808;       // MAC Control ethertype
            7:       w = 16'h0001;       // PAUSE opcode
            8:       w = quanta;
            default: w = '0;             // padding
        endcase
        return w;
    endfunction

endpackage

// File: rtl/pg_watermark.sv
module pg_watermark
    import pause_gen_pkg::*;
#(
    parameter int OCC_W     = 17,
    parameter int HIGH_MARK = 32768,
    parameter int LOW_MARK  = 19660
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occupancy,
    output pause_req_t       req
);

    localparam logic [OCC_W-1:0] HIGH_LVL = OCC_W'(HIGH_MARK);
    localparam logic [OCC_W-1:0] LOW_LVL  = OCC_W'(LOW_MARK);

    logic halted;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted <= 1'b0;
            req    <= '0;
        end else begin
            req <= '0;
            if (!halted && occupancy >= HIGH_LVL) begin
                halted     <= 1'b1;
                req.valid  <= 1'b1;
                req.halt   <= 1'b1;
            end else if (halted && occupancy <= LOW_LVL) begin
                halted     <= 1'b0;
                req.valid  <= 1'b1;
                req.halt   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pg_req_queue.sv
module pg_req_queue
    import pause_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  pause_req_t new_req,
    input  logic       take,
    output pause_req_t pending
);

    // Single slot: the newest request always overwrites an older one
    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
        end else if (new_req.valid) begin
            pending <= new_req;
        end else if (take) begin
            pending.valid <= 1'b0;
        end
    end

endmodule

// File: rtl/pg_frame_builder.sv
module pg_frame_builder
    import pause_gen_pkg::*;
#(
    parameter int MIN_FRAME_BYTES = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  pause_req_t        pending,
    input  logic [47:0]       local_mac,
    input  logic              tx_ready,
    output logic              take,
    output logic              tx_valid,
    output logic [WORD_W-1:0] tx_data,
    output logic              tx_sof,
    output logic              tx_eof
);

    localparam int FRAME_WORDS = MIN_FRAME_BYTES / 2;
    localparam int IDX_W       = $clog2(FRAME_WORDS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_WORDS - 1);
    localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_WORDS - 1);

    fb_state_e         state;
    logic [IDX_W-1:0]  idx;
    logic [WORD_W-1:0] quanta_q;
    logic [47:0]       mac_q;

    assign take     = (state == FB_IDLE) && pending.valid;
    assign tx_valid = (state != FB_IDLE);
    assign tx_data  = frame_word(int'(idx), mac_q, quanta_q);
    assign tx_sof   = tx_valid && (idx == '0);
    assign tx_eof   = tx_valid && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FB_IDLE;
            idx      <= '0;
            quanta_q <= '0;
            mac_q    <= '0;
        end else begin
            case (state)
                FB_IDLE: begin
                    if (pending.valid) begin
                        quanta_q <= quanta_of(pending.halt);
                        mac_q    <= local_mac;
                        idx      <= '0;
                        state    <= FB_HEADER;
                    end
                end
                FB_HEADER: begin
                    if (tx_ready) begin
                        idx <= idx + 1'b1;
                        if (idx == HDR_LAST) state <= FB_PAD;
                    end
                end
                FB_PAD: begin
                    if (tx_ready) begin
                        if (idx == LAST_IDX) begin
                            idx   <= '0;
                            state <= FB_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= FB_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
    import pause_gen_pkg::*;
#(
    parameter int CAP_BYTES       = 65536,
    parameter int HIGH_PCT        = 50,
    parameter int LOW_PCT         = 30,
    parameter int MIN_FRAME_BYTES = 60,
    localparam int OCC_W          = $clog2(CAP_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occupancy,
    input  logic [47:0]      local_mac,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [15:0]      tx_data,
    output logic             tx_sof,
    output logic             tx_eof
);

    localparam int HIGH_MARK = (CAP_BYTES * HIGH_PCT) / 100;
    localparam int LOW_MARK  = (CAP_BYTES * LOW_PCT) / 100;

    pause_req_t wm_req;
    pause_req_t pend_req;
    logic       take;

    pg_watermark #(
        .OCC_W     (OCC_W),
        .HIGH_MARK (HIGH_MARK),
        .LOW_MARK  (LOW_MARK)
    ) u_watermark (
        .clk       (clk),
        .rst       (rst),
        .occupancy (occupancy),
        .req       (wm_req)
    );

    pg_req_queue u_queue (
        .clk     (clk),
        .rst     (rst),
        .new_req (wm_req),
        .take    (take),
        .pending (pend_req)
    );

    pg_frame_builder #(
        .MIN_FRAME_BYTES (MIN_FRAME_BYTES)
    ) u_builder (
        .clk       (clk),
        .rst       (rst),
        .pending   (pend_req),
        .local_mac (local_mac),
        .tx_ready  (tx_ready),
        .take      (take),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sof    (tx_sof),
        .tx_eof    (tx_eof)
    );

endmodule

// File: rtl/pause_frame_gen_chk.sv
module pause_frame_gen_chk #(
    parameter int MIN_FRAME_BYTES = 60
) (
    input logic        clk,
    input logic        rst,
    input logic        tx_ready,
    input logic        tx_valid,
    input logic [15:0] tx_data,
    input logic        tx_sof,
    input logic        tx_eof
);

    localparam int FRAME_WORDS = MIN_FRAME_BYTES / 2;
    localparam int CNT_W       = $clog2(FRAME_WORDS) + 1;

    logic [CNT_W-1:0] cnt;

    // Accepted words since the start of the current frame
    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (tx_valid && tx_ready) cnt <= tx_eof ? '0 : cnt + 1'b1;
    end

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !tx_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof));

    p_dest_first_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid && cnt == '0 |-> tx_data == 16'h0180);

    p_quanta_value_r6: assert property (@(posedge clk) disable iff (rst)
        tx_valid && cnt == CNT_W'(8) |-> (tx_data == 16'hFFFF || tx_data == 16'h0000));

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid && cnt >= CNT_W'(9) |-> tx_data == 16'h0000);

    p_sof_position_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_sof |-> cnt == '0);

    p_eof_position_r7: assert property (@(posedge clk) disable iff (rst)
        tx_valid && tx_eof |-> cnt == CNT_W'(FRAME_WORDS - 1));

endmodule

bind pause_frame_gen pause_frame_gen_chk #(
    .MIN_FRAME_BYTES (MIN_FRAME_BYTES)
) u_pause_frame_gen_chk (
    .clk      (clk),
    .rst      (rst),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_sof   (tx_sof),
    .tx_eof   (tx_eof)
);

// File: tb/test_pause_frame_gen.sv
`timescale 1ns/1ps
module test_pause_frame_gen;

    localparam int FW   = 30;
    localparam int HIGH = 32768;
    localparam int LOW  = 19660;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [16:0] occupancy = '0;
    logic [47:0] local_mac = 48'h0;
    logic        tx_ready = 1'b1;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_sof;
    logic        tx_eof;

    int errors = 0;
    int checks = 0;
    logic [15:0] rx_words [FW];
    int rx_count;

    always #10 clk = ~clk;

    pause_frame_gen i_pause_frame_gen (
        .clk       (clk),
        .rst       (rst),
        .occupancy (occupancy),
        .local_mac (local_mac),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_sof    (tx_sof),
        .tx_eof    (tx_eof)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    function automatic logic [15:0] exp_word(input int i, input logic [47:0] mac, input logic [15:0] q);
        logic [15:0] hdr [9];
        hdr = '{16'h0180, 16'hC200, 16'h0001, mac[47:32], mac[31:16], mac[15:0], 16'h8808, 16'h0001, q};
        return (i < 9) ? hdr[i] : 16'h0000;
    endfunction

    task automatic recv_frame(input bit stall);
        int n = 0;
        int cyc = 0;
        bit done = 0;
        bit stalled = 0;
        logic [15:0] held = '0;
        while (!done && cyc < 400) begin
            if (stalled) check(tx_valid && tx_data == held, "R8", {15'd0, tx_valid, tx_data}, {16'd1, held});
            stalled = 0;
            tx_ready = !(stall && (cyc % 3 == 1));
            if (tx_valid && tx_ready) begin
                if (n < FW) rx_words[n] = tx_data;
                check(tx_sof == (n == 0) && tx_eof == (n == FW - 1), "R7",
                      {30'd0, tx_sof, tx_eof}, {30'd0, n == 0, n == FW - 1});
                if (tx_eof) done = 1;
                n++;
            end else if (tx_valid) begin
                stalled = 1;
                held = tx_data;
            end
            wait_cycles(1);
            cyc++;
        end
        tx_ready = 1'b1;
        rx_count = n;
        check(n == FW, "R7", n, FW);
    endtask

    task automatic compare_frame(input logic [47:0] mac, input logic [15:0] q);
        for (int i = 0; i < FW; i++) begin
            logic [15:0] e = exp_word(i, mac, q);
            check(rx_words[i] == e, (i >= 3 && i <= 5) ? "R10" : (i < 9 ? "R6" : "R7"), rx_words[i], e);
        end
    endtask

    task automatic wait_valid(input int max_cycles, input string req);
        int k = 0;
        while (!tx_valid && k < max_cycles) begin
            wait_cycles(1);
            k++;
        end
        check(tx_valid && tx_sof, req, {30'd0, tx_valid, tx_sof}, 32'd3);
    endtask

    task automatic expect_quiet(input int n, input string req);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            if (tx_valid) seen = 1;
            wait_cycles(1);
        end
        check(!seen, req, seen, 0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        wait_cycles(3);
        check(!tx_valid, "R1", tx_valid, 0);
        rst = 1'b0;
        expect_quiet(6, "R1");
    endtask

    task automatic t_below_marks;
        occupancy = 17'(HIGH - 1);
        expect_quiet(8, "R5");
        occupancy = 17'(LOW + 5);
        expect_quiet(8, "R5");
    endtask

    task automatic t_halt_frame;
        local_mac = 48'h0A1B_2C3D_4E5F;
        occupancy = 17'(HIGH);
        wait_cycles(2);
        check(!tx_valid, "R2", tx_valid, 0);
        wait_cycles(1);
        check(tx_valid && tx_sof, "R2", {30'd0, tx_valid, tx_sof}, 32'd3);
        local_mac = 48'hFFFF_0000_FFFF;   // latched copy must be used (R10)
        recv_frame(1'b0);
        compare_frame(48'h0A1B_2C3D_4E5F, 16'hFFFF);
    endtask

    task automatic t_no_repeat;
        occupancy = 17'(HIGH + 1000);
        expect_quiet(8, "R3");
        occupancy = 17'd65536;
        expect_quiet(8, "R3");
        occupancy = 17'(LOW + 1);
        expect_quiet(8, "R5");
    endtask

    task automatic t_resume_frame;
        local_mac = 48'h1234_5678_9ABC;
        occupancy = 17'(LOW);
        wait_cycles(3);
        check(tx_valid && tx_sof, "R4", {30'd0, tx_valid, tx_sof}, 32'd3);
        recv_frame(1'b1);
        compare_frame(48'h1234_5678_9ABC, 16'h0000);
        occupancy = 17'd0;
        expect_quiet(8, "R5");
    endtask

    task automatic t_queue_halt_wins;
        tx_ready = 1'b0;
        occupancy = 17'(HIGH);
        wait_cycles(4);
        occupancy = 17'd0;
        wait_cycles(3);
        occupancy = 17'(HIGH);
        wait_cycles(3);
        recv_frame(1'b0);
        check(rx_words[8] == 16'hFFFF, "R9", rx_words[8], 16'hFFFF);
        wait_valid(5, "R9");
        recv_frame(1'b0);
        check(rx_words[8] == 16'hFFFF, "R9", rx_words[8], 16'hFFFF);
        expect_quiet(10, "R9");
    endtask

    task automatic t_queue_resume_wins;
        tx_ready = 1'b0;
        occupancy = 17'(LOW);
        wait_cycles(4);
        occupancy = 17'(HIGH);
        wait_cycles(3);
        occupancy = 17'(LOW);
        wait_cycles(3);
        recv_frame(1'b1);
        check(rx_words[8] == 16'h0000, "R9", rx_words[8], 16'h0000);
        wait_valid(5, "R9");
        recv_frame(1'b0);
        check(rx_words[8] == 16'h0000, "R9", rx_words[8], 16'h0000);
        expect_quiet(10, "R9");
    endtask

    task automatic t_reset_abort;
        occupancy = 17'(HIGH);
        wait_cycles(6);
        check(tx_valid, "R1", tx_valid, 1);
        rst = 1'b1;
        occupancy = 17'd0;
        wait_cycles(1);
        check(!tx_valid, "R1", tx_valid, 0);
        rst = 1'b0;
        expect_quiet(8, "R1");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        #5;
        t_reset();
        t_below_marks();
        t_halt_frame();
        t_no_repeat();
        t_resume_frame();
        t_queue_halt_wins();
        occupancy = 17'(LOW);
        wait_valid(5, "R4");
        recv_frame(1'b0);
        compare_frame(48'h1234_5678_9ABC, 16'h0000);
        occupancy = 17'(HIGH);
        wait_valid(5, "R2");
        recv_frame(1'b0);
        t_queue_resume_wins();
        t_reset_abort();
        finish_run();
    end

endmodule